// File: doc/BRIEF.md
# Line-Controlled Serial Transmitter

This block is the transmit half of a byte-wide, register-programmed serial port. Software writes a line control byte that fixes the character format (5 to 8 data bits, one or two stop bits, optional parity with odd, even or forced value) and can hold the output line in a break. A bank-select bit in the same byte redirects two shared offsets from the data and interrupt-enable registers to the two bytes of a 16-bit baud divisor.

A byte written to the holding register is moved into the shifter as soon as the shifter is free and the divisor is nonzero. The shifter then sends a start bit, the data least significant bit first, the optional parity bit and the stop time. A baud tick generator, restarted at the start of every frame, paces each bit. One status byte reports whether the holding register is free and whether the whole transmitter is empty.

Top module: `uart_line_tx`

## Requirements
- R1: After reset TXD is 1, tx_empty is 1, the line control register (offset 3) reads 0x00, the status byte (offset 5) reads 0x60 and both divisor bytes read 0x00.
- R2: Line control bit 7 selects the bank of offsets 0 and 1. With it at 1 they write and read the low (offset 0) and high (offset 1) divisor bytes, and a write to offset 0 does not fill the holding register. With it at 0, offset 0 writes the holding register and reads 0x00, and offset 1 is an interrupt-enable register that keeps bits 3:0 and reads 0 above them.
- R3: The line control register holds bit 7 bank select, bit 6 break, bit 5 forced parity, bit 4 even select, bit 3 parity enable, bit 2 stop select and bits 1:0 word length. It reads back as written. Bus bits above bit 7 are ignored on writes and read as 0.
- R4: A frame is a start bit of 0, then the data bits least significant first, with word length codes 00, 01, 10 and 11 giving 5, 6, 7 and 8 bits. Unused upper data bits are not sent. TXD rests at 1 between frames.
- R5: The baud tick fires once every 16 × divisor clocks and every bit lasts 16 ticks, so a bit is 256 × divisor clocks. The start bit begins after the second rising edge following the holding-register write, or following the divisor write that makes the divisor nonzero. While the divisor is 0, a written byte waits and TXD stays 1.
- R6: With parity enabled and forced parity off, the parity bit follows the data and makes the count of ones in data plus parity even when bit 4 is 1, and odd when bit 4 is 0.
- R7: With parity enabled and forced parity on, the parity bit is the inverse of bit 4, regardless of the data.
- R8: With parity disabled, no parity bit is sent, and bits 4 and 5 have no effect on the frame.
- R9: Stop select 0 gives one stop bit of 1. Stop select 1 gives two stop bits, or 1.5 stop bits for 5-bit words. tx_empty rises on the clock edge that ends the stop time.
- R10: While the break bit is 1, TXD is 0. The shifter keeps its timing and contents, so after break is cleared the frame continues at its scheduled bit and ends on schedule.
- R11: tx_empty is 1 exactly when the holding register is empty and the shifter is idle. A byte written while the shifter is busy waits, and its start bit begins on the edge that ends the current frame's stop time.
- R12: The status byte at offset 5 reads bit 6 = tx_empty and bit 5 = holding register empty, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | ADDR_W (3) | Register offset |
| bus_wdata | input | BUS_W (32) | Write data; only bits 7:0 are used |
| bus_rdata | output | BUS_W (32) | Combinational read data for bus_addr |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | Holding register empty and shifter idle |

## Verification
Register writes land on the clock edge that samples the strobe, and read data is combinational, so register and status checks sample half a cycle after that edge. The line drops for a start bit one edge after the write (the holding register stage, then the shifter stage), and every later bit boundary falls a whole multiple of 256 × divisor clocks after that. The bench records the edge index of each write and samples every bit at its midpoint. It checks tx_empty on the last cycle of the stop time and on the first cycle after it, so that both a lost or extra tick and a wrong stop length show up. Break and back-to-back cases use the same edge arithmetic, so a frame that slips by even one tick is caught.

// File: rtl/uart_line_tx_pkg.sv
package uart_line_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 2 * BYTE_W;

    // register offsets
    localparam int OFF_DATA = 0;
    localparam int OFF_IER  = 1;
    localparam int OFF_LCR  = 3;
    localparam int OFF_STAT = 5;

    typedef struct packed {
        logic       dlab;
        logic       brk;
        logic       sticky;
        logic       even;
        logic       pen;
        logic       stop2;
        logic [1:0] wlen;
    } lcr_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

endpackage

// File: rtl/uart_line_tx_regs.sv
module uart_line_tx_regs
    import uart_line_tx_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 3,
    parameter int IER_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              pop,
    input  logic              tx_empty_i,
    output lcr_t              lcr,
    output logic [DIV_W-1:0]  divisor,
    output logic [BYTE_W-1:0] thr_byte,
    output logic              thr_full,
    output logic [BUS_W-1:0]  rdata
);

    typedef struct packed {
        lcr_t              lcr;
        logic [BYTE_W-1:0] dll;
        logic [BYTE_W-1:0] dlh;
        logic [IER_W-1:0]  ier;
        logic [BYTE_W-1:0] thr;
        logic              full;
    } regs_t;

    regs_t r_d, r_q;
    logic [BYTE_W-1:0] wbyte;
    logic [BYTE_W-1:0] rbyte;
    logic              hit_data, hit_ier, hit_lcr, hit_stat;
    logic              unused_hi;

    assign wbyte     = wdata[BYTE_W-1:0];
    assign unused_hi = &{1'b0, wdata[BUS_W-1:BYTE_W]};
    assign hit_data  = (addr == ADDR_W'(OFF_DATA));
    assign hit_ier   = (addr == ADDR_W'(OFF_IER));
    assign hit_lcr   = (addr == ADDR_W'(OFF_LCR));
    assign hit_stat  = (addr == ADDR_W'(OFF_STAT));

    always_comb begin
        r_d = r_q;
        if (pop) begin
            r_d.full = 1'b0;
        end
        if (wr_en) begin
            if (hit_lcr) begin
                r_d.lcr = lcr_t'(wbyte);
            end else if (hit_data && r_q.lcr.dlab) begin
                r_d.dll = wbyte;
            end else if (hit_data) begin
                r_d.thr  = wbyte;
                r_d.full = 1'b1;
            end else if (hit_ier && r_q.lcr.dlab) begin
                r_d.dlh = wbyte;
            end else if (hit_ier) begin
                r_d.ier = wbyte[IER_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rbyte = '0;
        if (hit_data) begin
            rbyte = r_q.lcr.dlab ? r_q.dll : '0;
        end else if (hit_ier) begin
            rbyte = r_q.lcr.dlab ? r_q.dlh : BYTE_W'(r_q.ier);
        end else if (hit_lcr) begin
            rbyte = r_q.lcr;
        end else if (hit_stat) begin
            rbyte = {1'b0, tx_empty_i, ~r_q.full, 5'b0};
        end
    end

    assign rdata    = BUS_W'(rbyte);
    assign lcr      = r_q.lcr;
    assign divisor  = {r_q.dlh, r_q.dll};
    assign thr_byte = r_q.thr;
    assign thr_full = r_q.full;

    AST_LCR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_lcr) |=> (lcr == $past(wbyte))); // R3
    AST_THR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_data && !lcr.dlab) |=> thr_full); // R2
    AST_DLAB_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_data && lcr.dlab && !thr_full) |=> !thr_full); // R2

endmodule

// File: rtl/uart_line_tx_baud.sv
module uart_line_tx_baud #(
    parameter int DIV_W    = 16,
    parameter int PRESCALE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    localparam int CNT_W = DIV_W + $clog2(PRESCALE);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } baud_t;

    baud_t            b_d, b_q;
    logic [CNT_W-1:0] last;
    logic             div_nz;

    assign div_nz = |divisor;
    assign last   = CNT_W'(divisor) * CNT_W'(PRESCALE) - CNT_W'(1);
    assign tick   = run && div_nz && (b_q.cnt >= last);

    always_comb begin
        b_d = b_q;
        if (!run || !div_nz || tick) begin
            b_d.cnt = '0;
        end else begin
            b_d.cnt = b_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5

endmodule

// File: rtl/uart_line_tx_shift.sv
module uart_line_tx_shift
    import uart_line_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              div_nz,
    input  logic              thr_full,
    input  logic [BYTE_W-1:0] thr_byte,
    input  lcr_t              fmt,
    output logic              pop,
    output logic              busy,
    output logic              line
);

    localparam int TCW     = $clog2(2 * TICKS_PER_BIT) + 1;
    localparam int STOP_1  = TICKS_PER_BIT;
    localparam int STOP_15 = TICKS_PER_BIT + TICKS_PER_BIT / 2;
    localparam int STOP_2  = 2 * TICKS_PER_BIT;

    typedef struct packed {
        tx_state_e         st;
        logic [BYTE_W-1:0] shreg;
        logic [2:0]        last_bit;
        logic [2:0]        bidx;
        logic [TCW-1:0]    tcnt;
        logic [TCW-1:0]    stop_len;
        logic              pen;
        logic              par;
        logic              line;
    } sh_t;

    localparam sh_t SH_RST = '{
        st: TX_IDLE, shreg: '0, last_bit: '0, bidx: '0,
        tcnt: '0, stop_len: '0, pen: 1'b0, par: 1'b0, line: 1'b1
    };

    sh_t               s_d, s_q;
    logic [BYTE_W-1:0] ld_mask, ld_data;
    logic              ld_par;
    logic [TCW-1:0]    ld_stop;
    logic [TCW-1:0]    slot_lim;
    logic              slot_end, can_load, do_load;
    logic              unused_fmt;

    assign unused_fmt = &{1'b0, fmt.dlab, fmt.brk};

    // frame format captured when a byte enters the shifter
    always_comb begin
        ld_mask = 8'hFF >> (2'd3 - fmt.wlen);
        ld_data = thr_byte & ld_mask;
        if (fmt.sticky) begin
            ld_par = ~fmt.even;
        end else if (fmt.even) begin
            ld_par = ^ld_data;
        end else begin
            ld_par = ~^ld_data;
        end
        if (!fmt.stop2) begin
            ld_stop = TCW'(STOP_1);
        end else if (fmt.wlen == 2'b00) begin
            ld_stop = TCW'(STOP_15);
        end else begin
            ld_stop = TCW'(STOP_2);
        end
    end

    assign can_load = thr_full && div_nz;
    assign slot_lim = (s_q.st == TX_STOP) ? s_q.stop_len : TCW'(TICKS_PER_BIT);
    assign slot_end = tick && (s_q.tcnt == slot_lim - TCW'(1));

    always_comb begin
        s_d     = s_q;
        do_load = 1'b0;
        if (slot_end) begin
            s_d.tcnt = '0;
        end else if (tick) begin
            s_d.tcnt = s_q.tcnt + TCW'(1);
        end
        case (s_q.st)
            TX_IDLE: begin
                do_load = can_load;
            end
            TX_START: begin
                if (slot_end) begin
                    s_d.st   = TX_DATA;
                    s_d.bidx = '0;
                    s_d.line = s_q.shreg[0];
                end
            end
            TX_DATA: begin
                if (slot_end) begin
                    if (s_q.bidx == s_q.last_bit) begin
                        s_d.st   = s_q.pen ? TX_PAR : TX_STOP;
                        s_d.line = s_q.pen ? s_q.par : 1'b1;
                    end else begin
                        s_d.bidx  = s_q.bidx + 3'd1;
                        s_d.shreg = s_q.shreg >> 1;
                        s_d.line  = s_q.shreg[1];
                    end
                end
            end
            TX_PAR: begin
                if (slot_end) begin
                    s_d.st   = TX_STOP;
                    s_d.line = 1'b1;
                end
            end
            TX_STOP: begin
                if (slot_end) begin
                    if (can_load) begin
                        do_load = 1'b1;
                    end else begin
                        s_d.st = TX_IDLE;
                    end
                end
            end
            default: begin
                s_d = SH_RST;
            end
        endcase
        if (do_load) begin
            s_d.st       = TX_START;
            s_d.shreg    = ld_data;
            s_d.last_bit = 3'd4 + {1'b0, fmt.wlen};
            s_d.bidx     = '0;
            s_d.tcnt     = '0;
            s_d.stop_len = ld_stop;
            s_d.pen      = fmt.pen;
            s_d.par      = ld_par;
            s_d.line     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SH_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign pop  = do_load;
    assign busy = (s_q.st != TX_IDLE);
    assign line = s_q.line;

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == TX_IDLE) |-> s_q.line); // R4
    AST_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == TX_START) |-> !s_q.line); // R4
    AST_STOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == TX_STOP) |-> s_q.line); // R9
    AST_DIV0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == TX_IDLE) && !div_nz) |=> (s_q.st == TX_IDLE)); // R5
    AST_POP_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> thr_full); // R11

endmodule

// File: rtl/uart_line_tx.sv
module uart_line_tx
    import uart_line_tx_pkg::*;
#(
    parameter int BUS_W         = 32,
    parameter int ADDR_W        = 3,
    parameter int PRESCALE      = 16,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              txd,
    output logic              tx_empty
);

    lcr_t              lcr;
    logic [DIV_W-1:0]  divisor;
    logic [BYTE_W-1:0] thr_byte;
    logic              thr_full, pop, busy, line, tick;

    assign tx_empty = !thr_full && !busy;
    assign txd      = lcr.brk ? 1'b0 : line;

    uart_line_tx_regs #(
        .BUS_W  (BUS_W),
        .ADDR_W (ADDR_W),
        .IER_W  (4)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .pop        (pop),
        .tx_empty_i (tx_empty),
        .lcr        (lcr),
        .divisor    (divisor),
        .thr_byte   (thr_byte),
        .thr_full   (thr_full),
        .rdata      (bus_rdata)
    );

    uart_line_tx_baud #(
        .DIV_W    (DIV_W),
        .PRESCALE (PRESCALE)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .divisor (divisor),
        .tick    (tick)
    );

    uart_line_tx_shift #(
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .div_nz   (|divisor),
        .thr_full (thr_full),
        .thr_byte (thr_byte),
        .fmt      (lcr),
        .pop      (pop),
        .busy     (busy),
        .line     (line)
    );

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (txd || lcr.brk)); // R11
    AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcr.brk) |-> !txd); // R10

endmodule

// File: tb/uart_line_tx_test.sv
`timescale 1ns/1ps
module uart_line_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd, tx_empty;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_line_tx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .txd       (txd),
        .tx_empty  (tx_empty)
    );

    typedef struct packed {
        logic [7:0] lcr;
        logic [7:0] data;
        logic [3:0] nbits;
        logic [1:0] par;   // 2 = no parity bit
        logic [2:0] sh;    // stop time in half bits
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'h03, 8'hA5, 4'd8, 2'd2, 3'd2},
        '{8'h00, 8'h35, 4'd5, 2'd2, 3'd2},
        '{8'h01, 8'hC9, 4'd6, 2'd2, 3'd2},
        '{8'h02, 8'h5A, 4'd7, 2'd2, 3'd2},
        '{8'h1B, 8'hA5, 4'd8, 2'd0, 3'd2},
        '{8'h0B, 8'hA5, 4'd8, 2'd1, 3'd2},
        '{8'h1B, 8'h07, 4'd8, 2'd1, 3'd2},
        '{8'h3B, 8'h07, 4'd8, 2'd0, 3'd2},
        '{8'h2B, 8'hA5, 4'd8, 2'd1, 3'd2},
        '{8'h33, 8'hFF, 4'd8, 2'd2, 3'd2},
        '{8'h07, 8'h3C, 4'd8, 2'd2, 3'd4},
        '{8'h04, 8'h0A, 4'd5, 2'd2, 3'd3},
        '{8'h0C, 8'h0A, 4'd5, 2'd1, 3'd3},
        '{8'h1E, 8'hFF, 4'd7, 2'd1, 3'd4},
        '{8'h12, 8'h80, 4'd7, 2'd2, 3'd2}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d, output int w);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 3'(a);
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        w      = cyc;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = 3'(a);
        #1 v = bus_rdata;
    endtask

    function automatic string ptag_of(input logic [7:0] l);
        if (l[3] && l[5]) return "R7";
        if (l[3]) return "R6";
        if (l[5] || l[4]) return "R8";
        return "R4";
    endfunction

    task automatic check_frame(input int w, input logic [7:0] data, input int n,
                               input int par, input int sh, input int bitc,
                               input bit idle_end, input string ptag, input string ttag);
        int base, pos, fin;
        base = w + 1;
        wait_until(base + bitc / 2);
        chk(txd == 1'b0, ttag, "start bit", int'(txd), 0);
        for (int i = 0; i < n; i++) begin
            wait_until(base + bitc * (1 + i) + bitc / 2);
            chk(txd == data[i], "R4", $sformatf("data bit %0d", i), int'(txd), int'(data[i]));
        end
        pos = 1 + n;
        if (par != 2) begin
            wait_until(base + bitc * pos + bitc / 2);
            chk(txd == par[0], ptag, "parity bit", int'(txd), par);
            pos++;
        end
        wait_until(base + bitc * pos + sh * bitc / 4);
        chk(txd == 1'b1, (par == 2) ? ptag : "R9", "stop bit", int'(txd), 1);
        fin = base + bitc * pos + sh * bitc / 2;
        wait_until(fin - 1);
        chk(tx_empty == 1'b0, "R9", "busy at last stop cycle", int'(tx_empty), 0);
        wait_until(fin);
        chk(tx_empty == idle_end, ttag, "tx_empty after stop", int'(tx_empty), int'(idle_end));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int w, d, base, e;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
        rd(3, v); chk(v == 32'h00, "R1", "lcr after reset", v, 0);
        rd(5, v); chk(v == 32'h60, "R1", "status after reset", v, 32'h60);
        wr(3, 32'h80, d);
        rd(0, v); chk(v == 32'h00, "R1", "divisor low after reset", v, 0);
        rd(1, v); chk(v == 32'h00, "R1", "divisor high after reset", v, 0);
        wr(3, 32'h00, d);

        // R5: divisor 0 holds a written byte
        wr(0, 32'h55, d);
        repeat (2000) @(negedge clk);
        chk(txd == 1'b1, "R5", "txd with divisor 0", int'(txd), 1);
        chk(tx_empty == 1'b0, "R5", "tx_empty with byte waiting", int'(tx_empty), 0);
        rd(5, v); chk(v == 32'h00, "R12", "status with byte waiting", v, 0);
        wr(3, 32'h83, d);
        wr(0, 32'h01, w);
        check_frame(w, 8'h55, 8, 2, 2, 256, 1'b1, "R4", "R5");
        wr(3, 32'h03, d);

        // format vectors
        for (int k = 0; k < NV; k++) begin
            wr(3, 32'(VEC[k].lcr), d);
            wr(0, 32'(VEC[k].data), w);
            check_frame(w, VEC[k].data, int'(VEC[k].nbits), int'(VEC[k].par),
                        int'(VEC[k].sh), 256, 1'b1, ptag_of(VEC[k].lcr), "R4");
        end

        // R11 / R12: second byte waits for the first frame
        wr(3, 32'h03, d);
        wr(0, 32'h96, w);
        wait_until(w + 1);
        rd(5, v); chk(v == 32'h20, "R12", "status while shifting", v, 32'h20);
        wr(0, 32'h3C, d);
        rd(5, v); chk(v == 32'h00, "R12", "status with byte held", v, 0);
        chk(tx_empty == 1'b0, "R11", "tx_empty with byte held", int'(tx_empty), 0);
        check_frame(w, 8'h96, 8, 2, 2, 256, 1'b0, "R4", "R11");
        e = w + 1 + 256 * 9 + 128 * 2;
        check_frame(e - 1, 8'h3C, 8, 2, 2, 256, 1'b1, "R4", "R11");

        // R10: break forces space, shifter keeps going
        wr(0, 32'h2F, w);
        base = w + 1;
        wait_until(base + 2 * 256 + 128);
        wr(3, 32'h43, d);
        wait_until(base + 3 * 256 + 128);
        chk(txd == 1'b0, "R10", "txd under break", int'(txd), 0);
        chk(tx_empty == 1'b0, "R10", "shifter busy under break", int'(tx_empty), 0);
        wait_until(base + 5 * 256 + 20);
        wr(3, 32'h03, d);
        wait_until(base + 6 * 256 + 128);
        chk(txd == 1'b1, "R10", "bit 5 after break", int'(txd), 1);
        wait_until(base + 7 * 256 + 128);
        chk(txd == 1'b0, "R10", "bit 6 after break", int'(txd), 0);
        wait_until(base + 9 * 256 + 128);
        chk(txd == 1'b1, "R10", "stop after break", int'(txd), 1);
        wait_until(base + 10 * 256 - 1);
        chk(tx_empty == 1'b0, "R10", "busy at scheduled end-1", int'(tx_empty), 0);
        wait_until(base + 10 * 256);
        chk(tx_empty == 1'b1, "R10", "idle at scheduled end", int'(tx_empty), 1);

        // R5: divisor 2 doubles every bit
        wr(3, 32'h83, d);
        wr(0, 32'h02, d);
        wr(3, 32'h03, d);
        wr(0, 32'hC3, w);
        check_frame(w, 8'hC3, 8, 2, 2, 512, 1'b1, "R4", "R5");

        // R2 / R3: register window and reserved bits
        wr(3, 32'h80, d);
        wr(0, 32'h34, d);
        wr(1, 32'h12, d);
        rd(0, v); chk(v == 32'h34, "R2", "divisor low readback", v, 32'h34);
        rd(1, v); chk(v == 32'h12, "R2", "divisor high readback", v, 32'h12);
        chk(tx_empty == 1'b1, "R2", "bank 1 write leaves holding empty", int'(tx_empty), 1);
        rd(5, v); chk(v == 32'h60, "R2", "status after bank 1 write", v, 32'h60);
        wr(3, 32'hFFFF_FF3B, d);
        rd(3, v); chk(v == 32'h3B, "R3", "lcr with reserved bits", v, 32'h3B);
        wr(1, 32'hFF, d);
        rd(1, v); chk(v == 32'h0F, "R2", "interrupt enable readback", v, 32'h0F);
        rd(0, v); chk(v == 32'h00, "R2", "data offset read in bank 0", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule